// File: doc/BRIEF.md
# Programmable Asynchronous Bus Cycle Sequencer

This block runs a single access on an asynchronous 16-bit parallel bus, such as a disk-style or memory-card register port in programmed I/O mode. A request carries an address, a read/write flag and write data. Once the sequencer accepts it, the sequencer drives the address, pulls the chip enable low, issues the read or write strobe, holds and then pauses. It then signals completion with a one-cycle done pulse, which carries the captured read data.

Timing is set by a group of 6-bit phase fields and a 2-bit prescale code. Every field uses minus-one encoding, so a value N lasts N+1 prescaled ticks. The sequencer samples all fields and the wait-mode enable when it accepts the request, so later changes do not affect an access that is already running. When wait mode is on, the device can hold its ready line low to stretch the strobe. That line goes through a two-flop synchronizer before it is used.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and its payload stable until that edge. The response side has no back-pressure: `done` is high for exactly one cycle, and `rsp_rdata` is valid in that cycle and stays unchanged until the next read completes.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset, `busy` and `done` are low, `req_ready` is high, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `bus_dout_en` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle until the cycle of the done pulse, in which it is low again. `req_ready` is low whenever `busy` is high.
- R3: An access runs through five phases in a fixed order. Each phase lasts (N+1)×M clocks, where N is its field and M is the prescale factor. The phases are: setup (address driven, chip enable high), enable-to-strobe delay (chip enable low, strobes high), strobe (chip enable and one strobe low), hold (chip enable low, strobes high) and pause (chip enable high).
- R4: The prescale code `cfg_mult` gives M = 4 for code 0, M = 1 for code 1, M = 2 for code 2 and M = 8 for code 3.
- R5: A read pulls only `bus_rd_n` low and uses `cfg_t_rd_stb` and `cfg_t_rd_hold`. A write pulls only `bus_wr_n` low and uses `cfg_t_wr_stb` and `cfg_t_wr_hold`.
- R6: During a write, `bus_dout_en` is high from the first cycle of the enable-to-strobe delay through the last cycle of the hold phase, and `bus_dout` equals the write data. `bus_dout_en` is never high during a read.
- R7: Read data is the value `bus_din` has in the last cycle of the read strobe, captured on the edge where the strobe is released. It is presented on `rsp_rdata` in the cycle where `done` is high for one cycle, and `done` follows the last pause cycle.
- R8: With `cfg_wait_en` low, `bus_ready` has no effect on any phase length.
- R9: With `cfg_wait_en` high, each cycle in which `bus_ready` is low during the strobe (seen after the two-flop synchronizer) adds one clock to the strobe phase.
- R10: The largest field value, 63, gives a phase of 64 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_mult | input | 2 | Prescale code |
| cfg_wait_en | input | 1 | Allow ready line to stretch the strobe |
| cfg_t_setup | input | CNT_W | Address setup before chip enable, minus one |
| cfg_t_ce | input | CNT_W | Chip enable to strobe delay, minus one |
| cfg_t_rd_stb | input | CNT_W | Read strobe width, minus one |
| cfg_t_wr_stb | input | CNT_W | Write strobe width, minus one |
| cfg_t_rd_hold | input | CNT_W | Hold after read strobe, minus one |
| cfg_t_wr_hold | input | CNT_W | Hold after write strobe, minus one |
| cfg_t_pause | input | CNT_W | Trailing pause, minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | 1 | Chip enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Write data to bus |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | DATA_W | Read data from bus |
| bus_ready | input | 1 | Device ready, low to stretch the strobe |

## Verification
Reads and writes use deliberately different strobe and hold fields. A swapped field selection or the wrong strobe line therefore shows up as a wrong phase length. The same field set is run under all four prescale codes, which exposes a wrong code-to-factor mapping, and an all-zero set and a maximum-width strobe cover both ends of the field range. The modelled device changes `bus_din` on every strobe cycle, so only sampling in the final strobe cycle returns the expected word. Identical ready-line drops with wait mode off and on separate the case where the line is ignored from the case where it stretches the strobe by exactly the drop length. A request is also offered early while the sequencer is still busy, to show that it waits its turn.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_CE, PH_STB, PH_HOLD, PH_PAUSE
  } phase_e;

  function automatic logic [3:0] mult_clocks(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bcs_phase_timer.sv
module bcs_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [1:0]       mult_code,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  import bcs_pkg::*;

  logic [3:0]       pre_q;
  logic [CNT_W-1:0] tick_q;
  logic [3:0]       span;
  logic             wrap;

  assign span = mult_clocks(mult_code);
  assign wrap = (pre_q == span - 4'd1);
  assign last = wrap && (tick_q == limit) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (clr) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (!hold) begin
      if (wrap) begin
        pre_q  <= '0;
        tick_q <= tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 4'd1;
      end
    end
  end

  assert_prescale_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < span);
  assert_freeze_on_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> (pre_q == $past(pre_q) && tick_q == $past(tick_q)));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_mult,
  input  logic              cfg_wait_en,
  input  logic [CNT_W-1:0]  cfg_t_setup,
  input  logic [CNT_W-1:0]  cfg_t_ce,
  input  logic [CNT_W-1:0]  cfg_t_rd_stb,
  input  logic [CNT_W-1:0]  cfg_t_wr_stb,
  input  logic [CNT_W-1:0]  cfg_t_rd_hold,
  input  logic [CNT_W-1:0]  cfg_t_wr_hold,
  input  logic [CNT_W-1:0]  cfg_t_pause,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ready
);
  import bcs_pkg::*;

  phase_e            ph_q;
  logic              wr_q, wait_q, done_q;
  logic [1:0]        mult_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  su_q, ce_q, rstb_q, wstb_q, rhld_q, whld_q, pau_q;
  logic [CNT_W-1:0]  limit;
  logic              accept, last, hold, rdy_s, clr;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign hold      = (ph_q == PH_STB) && wait_q && !rdy_s;
  assign clr       = last || (ph_q == PH_IDLE);

  always_comb begin
    case (ph_q)
      PH_SETUP: limit = su_q;
      PH_CE:    limit = ce_q;
      PH_STB:   limit = wr_q ? wstb_q : rstb_q;
      PH_HOLD:  limit = wr_q ? whld_q : rhld_q;
      PH_PAUSE: limit = pau_q;
      default:  limit = '0;
    endcase
  end

  bcs_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ready), .q(rdy_s)
  );

  bcs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
    .mult_code(mult_q), .limit(limit), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      wr_q    <= 1'b0;
      wait_q  <= 1'b0;
      mult_q  <= 2'd1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      su_q    <= '0;
      ce_q    <= '0;
      rstb_q  <= '0;
      wstb_q  <= '0;
      rhld_q  <= '0;
      whld_q  <= '0;
      pau_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ph_q    <= PH_SETUP;
        wr_q    <= req_wr;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mult_q  <= cfg_mult;
        wait_q  <= cfg_wait_en;
        su_q    <= cfg_t_setup;
        ce_q    <= cfg_t_ce;
        rstb_q  <= cfg_t_rd_stb;
        wstb_q  <= cfg_t_wr_stb;
        rhld_q  <= cfg_t_rd_hold;
        whld_q  <= cfg_t_wr_hold;
        pau_q   <= cfg_t_pause;
      end else if (last) begin
        case (ph_q)
          PH_SETUP: ph_q <= PH_CE;
          PH_CE:    ph_q <= PH_STB;
          PH_STB: begin
            ph_q <= PH_HOLD;
            if (!wr_q) rdata_q <= bus_din;
          end
          PH_HOLD:  ph_q <= PH_PAUSE;
          PH_PAUSE: begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
          default:  ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy        = (ph_q != PH_IDLE);
  assign done        = done_q;
  assign rsp_rdata   = rdata_q;
  assign bus_addr    = addr_q;
  assign bus_cs_n    = !(ph_q == PH_CE || ph_q == PH_STB || ph_q == PH_HOLD);
  assign bus_rd_n    = !((ph_q == PH_STB) && !wr_q);
  assign bus_wr_n    = !((ph_q == PH_STB) && wr_q);
  assign bus_dout    = wdata_q;
  assign bus_dout_en = wr_q && !bus_cs_n;

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_strobe_inside_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  assert_driver_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> (bus_rd_n && !bus_cs_n));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0, req_ready;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  cfg_mult = 2'd1;
  logic        cfg_wait_en = 1'b0;
  logic [5:0]  c_su = '0, c_ce = '0, c_rs = '0, c_ws = '0, c_rh = '0, c_wh = '0, c_pa = '0;
  logic        busy, done, bus_cs_n, bus_rd_n, bus_wr_n, bus_dout_en;
  logic [15:0] rsp_rdata, bus_dout;
  logic [15:0] bus_din = 16'hDEAD;
  logic [7:0]  bus_addr;
  logic        bus_ready = 1'b1;

  int tests = 0, fails = 0, cycles = 0, drop_k = 0, dcnt = 0, busy_ready_bad = 0;

  typedef struct {
    string tag; bit wr; logic [15:0] wdata; logic [15:0] rdata;
    int a, c, s, h, p, oe;
  } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_mult(cfg_mult), .cfg_wait_en(cfg_wait_en),
    .cfg_t_setup(c_su), .cfg_t_ce(c_ce), .cfg_t_rd_stb(c_rs), .cfg_t_wr_stb(c_ws),
    .cfg_t_rd_hold(c_rh), .cfg_t_wr_hold(c_wh), .cfg_t_pause(c_pa),
    .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ready(bus_ready)
  );

  task automatic check(input string tag, input string what, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // device model: data changes every strobe cycle, optional ready drop
  always @(negedge clk) begin
    if (!bus_rd_n) begin
      dcnt = dcnt + 1;
      bus_din <= {bus_addr, 8'h00} ^ 16'(dcnt);
      bus_ready <= !(drop_k > 0 && dcnt >= 4 && dcnt < 4 + drop_k);
    end else begin
      dcnt = 0;
      bus_din <= 16'hDEAD;
      bus_ready <= 1'b1;
    end
    if (busy && req_ready) busy_ready_bad++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int mfac(input int code);
    case (code) 0: return 4; 1: return 1; 2: return 2; default: return 8; endcase
  endfunction

  task automatic access(input string tag, input bit wr, input logic [7:0] a,
                        input logic [15:0] wd, input int mc, input int su, input int ce,
                        input int rs, input int ws, input int rh, input int wh,
                        input int pa, input bit wen, input int drop, input bit early);
    item_t it;
    int m;
    m = mfac(mc);
    @(negedge clk);
    if (!early) while (!req_ready) @(negedge clk);
    else while (!busy) @(negedge clk);
    req_wr = wr; req_addr = a; req_wdata = wd; cfg_mult = 2'(mc);
    c_su = 6'(su); c_ce = 6'(ce); c_rs = 6'(rs); c_ws = 6'(ws);
    c_rh = 6'(rh); c_wh = 6'(wh); c_pa = 6'(pa); cfg_wait_en = wen;
    it.tag = tag; it.wr = wr; it.wdata = wd;
    it.a = (su + 1) * m; it.c = (ce + 1) * m;
    it.s = ((wr ? ws : rs) + 1) * m + ((wen && !wr) ? drop : 0);
    it.h = ((wr ? wh : rh) + 1) * m; it.p = (pa + 1) * m;
    it.oe = wr ? (it.c + it.s + it.h) : 0;
    it.rdata = {a, 8'h00} ^ 16'(it.s);
    exp_q.push_back(it);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (!early) while (busy) @(negedge clk);
    drop_k = drop;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    int a, c, s, h, p, oe, dbad, sbad;
    bit seen;
    forever begin
      @(negedge clk);
      if (busy) begin
        it = exp_q.pop_front();
        a = 0; c = 0; s = 0; h = 0; p = 0; oe = 0; dbad = 0; sbad = 0; seen = 0;
        while (busy) begin
          if (!bus_rd_n || !bus_wr_n) begin
            s++; seen = 1;
            if (it.wr ? !bus_rd_n : !bus_wr_n) sbad++;
          end else if (!bus_cs_n) begin
            if (seen) h++; else c++;
          end else begin
            if (seen) p++; else a++;
          end
          if (bus_dout_en) begin
            oe++;
            if (bus_dout !== it.wdata) dbad++;
          end
          @(negedge clk);
        end
        check(it.tag, "R3 setup length", a, it.a);
        check(it.tag, "R3 enable delay length", c, it.c);
        check(it.tag, "R5 strobe length", s, it.s);
        check(it.tag, "R5 hold length", h, it.h);
        check(it.tag, "R3 pause length", p, it.p);
        check(it.tag, "R5 wrong strobe cycles", sbad, 0);
        check(it.tag, "R6 driver enable cycles", oe, it.oe);
        check(it.tag, "R6 write data mismatches", dbad, 0);
        check(it.tag, "R7 done pulse", int'(done), 1);
        if (!it.wr) check(it.tag, "R7 read data", int'(rsp_rdata), int'(it.rdata));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "ready in reset", int'(req_ready), 1);
    check("R1", "strobes/enable in reset", int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
    check("R1", "driver/done in reset", int'({bus_dout_en, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R5 basic read then write offered early (R2)
    access("R3", 0, 8'h12, 16'h0, 1, 2, 1, 5, 9, 3, 4, 2, 0, 0, 0);
    access("R2", 1, 8'h34, 16'hA5C3, 1, 2, 1, 5, 9, 3, 4, 2, 0, 0, 1);
    // R4 prescale codes
    access("R4", 0, 8'h56, 16'h0, 2, 2, 1, 5, 9, 3, 4, 2, 0, 0, 0);
    access("R4", 1, 8'h78, 16'h3C5A, 0, 2, 1, 5, 9, 3, 4, 2, 0, 0, 0);
    access("R4", 0, 8'h9A, 16'h0, 3, 2, 1, 5, 9, 3, 4, 2, 0, 0, 0);
    // minimum fields, R10 maximum strobe
    access("R3", 0, 8'hBC, 16'h0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    access("R10", 0, 8'hDE, 16'h0, 1, 1, 1, 63, 0, 1, 1, 1, 0, 0, 0);
    access("R10", 1, 8'hEF, 16'h1234, 1, 1, 1, 0, 63, 1, 1, 1, 0, 0, 0);
    // R8 ready ignored, R9 ready stretches
    access("R8", 0, 8'h21, 16'h0, 1, 1, 1, 19, 2, 1, 1, 1, 0, 5, 0);
    access("R9", 0, 8'h43, 16'h0, 1, 1, 1, 19, 2, 1, 1, 1, 1, 5, 0);
    access("R9", 0, 8'h65, 16'h0, 2, 1, 1, 19, 2, 1, 1, 1, 1, 3, 0);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R2", "ready high while busy (cycles)", busy_ready_bad, 0);
    check("R2", "idle after last access", int'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule